// File: doc/BRIEF.md
# Rank Refresh and Power-State Controller

This block sits beside the command scheduler of one memory rank. An internal interval timer marks when a refresh is due. The controller then stops the rank from taking new work. It waits until outstanding column accesses have finished and the rank is out of any power-down state. If any banks are open, it closes them with a precharge-all command, then issues the refresh command and holds the rank for the refresh recovery time. After that recovery, the rank is released and the interval timer restarts.

Alongside the refresh sequencer, a power-state tracker follows the rank through these states: all banks closed, some banks open, refreshing, power-down with banks closed, power-down with banks open, and the exit from power-down. The scheduler supplies three inputs: the count of open banks, a flag for outstanding accesses, and an idle hint. Power-down is entered only when the rank is quiet. It is left when a new request arrives, when the hint is withdrawn, or when a refresh comes due. The exit costs a fixed number of cycles before a command may be issued.

Top module: `rank_pwr_ref_ctrl`

## Requirements
- R1: During reset, `rank_avail_o`=1, `pd_o`=0, `pwr_state_o`=0, and no command output is asserted.
- R2: The rank stays available for exactly T_REFI cycles after reset, and again after each refresh completes. `rank_avail_o` then falls in the cycle in which the drain begins, provided the rank is not in power-down.
- R3: While `busy_i` is high during the drain, neither `pre_all_o` nor `refresh_o` is asserted, and `rank_avail_o` stays low.
- R4: If the drain ends with `act_banks_i` nonzero, `pre_all_o` pulses for exactly one cycle, and `refresh_o` pulses T_RP cycles later.
- R5: If the drain ends with `act_banks_i` zero, `refresh_o` pulses in that same cycle and `pre_all_o` is not asserted.
- R6: After each `refresh_o` pulse, `pwr_state_o` reads 2 (refreshing), and `rank_avail_o` rises again T_RFC+1 cycles after the pulse.
- R7: Outside refresh and power-down, `pwr_state_o` follows the bank count: it reads 0 when `act_banks_i` is zero and 1 otherwise.
- R8: Power-down is entered on the next cycle when `idle_hint_i` is high, `busy_i` and `new_req_i` are low, and no refresh is due or in progress. The state reads 3 with no banks open and 4 with banks open, and `pd_o` is high while in it.
- R9: Power-down is left on `new_req_i`, on loss of `idle_hint_i`, or on the refresh timer expiring. `pwr_state_o` then reads 5 and `rank_avail_o` stays low for T_XP cycles.
- R10: `rank_avail_o` is low whenever `pd_o` is high, and no command is issued while in power-down.
- R11: A drain that starts while the rank is in power-down holds back its precharge-all or refresh until the power-down exit window has elapsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| act_banks_i | input | $clog2(NUM_BANKS+1) | Number of banks currently open |
| busy_i | input | 1 | Column accesses still outstanding |
| idle_hint_i | input | 1 | Scheduler reports no pending work |
| new_req_i | input | 1 | A request has arrived for this rank |
| rank_avail_o | output | 1 | Rank may be given new commands |
| pre_all_o | output | 1 | Precharge-all command, one-cycle pulse |
| refresh_o | output | 1 | Refresh command, one-cycle pulse |
| pd_o | output | 1 | Rank is held in power-down |
| pwr_state_o | output | 3 | Power state: 0 idle, 1 active, 2 refresh, 3 closed-bank power-down, 4 open-bank power-down, 5 exiting |

## Verification
The colliding pair is the refresh timer expiring while the rank sits in open-bank power-down. The bench parks the rank in power-down with three banks open and lets the interval run out there. It expects `pd_o` to drop on the next cycle and the exit window to run. It expects the precharge-all to appear only in the first cycle after that window, followed by the refresh T_RP cycles later. A scoreboard holds the exact cycle and kind of every expected command and flags any pulse that is early, late or unexpected. This also catches a drain that ignores outstanding accesses.

// File: rtl/rank_ctrl_pkg.sv
package rank_ctrl_pkg;

  typedef enum logic [1:0] {
    REF_IDLE  = 2'd0,
    REF_DRAIN = 2'd1,
    REF_PREALL = 2'd2,
    REF_BUSY  = 2'd3
  } ref_state_e;

  typedef enum logic [2:0] {
    PS_IDLE   = 3'd0,
    PS_ACT    = 3'd1,
    PS_REF    = 3'd2,
    PS_PD_PRE = 3'd3,
    PS_PD_ACT = 3'd4,
    PS_EXIT   = 3'd5
  } pwr_state_e;

endpackage

// File: rtl/rank_ref_timer.sv
module rank_ref_timer #(
  parameter int unsigned T_REFI = 7800
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_idle_i,
  input  logic reload_i,
  output logic due_o
);
  localparam int unsigned CW = (T_REFI > 2) ? $clog2(T_REFI) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= CW'(T_REFI - 1);
    else if (reload_i)       cnt_q <= CW'(T_REFI - 1);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign due_o = ref_idle_i && (cnt_q == '0);

  a_r2_due_only_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    due_o |=> !ref_idle_i);

endmodule

// File: rtl/rank_ref_fsm.sv
module rank_ref_fsm
  import rank_ctrl_pkg::*;
#(
  parameter int unsigned T_RP  = 12,
  parameter int unsigned T_RFC = 280
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       due_i,
  input  logic       busy_i,
  input  logic       banks_open_i,
  input  logic       pwr_ready_i,
  output ref_state_e state_o,
  output logic       pre_all_o,
  output logic       refresh_o,
  output logic       done_o
);
  localparam int unsigned MAXW = (T_RP > T_RFC) ? T_RP : T_RFC;
  localparam int unsigned WW   = $clog2(MAXW + 1);

  ref_state_e st_q, st_d;
  logic [WW-1:0] wcnt_q;
  logic go, wdone;

  assign go    = !busy_i && pwr_ready_i;
  assign wdone = (wcnt_q == '0);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      REF_IDLE:   if (due_i) st_d = REF_DRAIN;
      REF_DRAIN:  if (go) st_d = banks_open_i ? REF_PREALL : REF_BUSY;
      REF_PREALL: if (wdone) st_d = REF_BUSY;
      REF_BUSY:   if (wdone) st_d = REF_IDLE;
      default:    st_d = REF_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= REF_IDLE;
      wcnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q != REF_PREALL && st_d == REF_PREALL)   wcnt_q <= WW'(T_RP - 1);
      else if (st_q != REF_BUSY && st_d == REF_BUSY)  wcnt_q <= WW'(T_RFC - 1);
      else if (!wdone)                                 wcnt_q <= wcnt_q - 1'b1;
    end
  end

  assign state_o   = st_q;
  assign pre_all_o = (st_q == REF_DRAIN) && go && banks_open_i;
  assign refresh_o = ((st_q == REF_DRAIN) && go && !banks_open_i) ||
                     ((st_q == REF_PREALL) && wdone);
  assign done_o    = (st_q == REF_BUSY) && wdone;

  a_r3_no_cmd_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_all_o || refresh_o) |-> !busy_i);
  a_r4_single_pre: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_all_o |=> !pre_all_o);
  a_r4_cmd_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pre_all_o, refresh_o}));
  a_r6_single_ref: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_o |=> !refresh_o);

endmodule

// File: rtl/rank_pwr_fsm.sv
module rank_pwr_fsm
  import rank_ctrl_pkg::*;
#(
  parameter int unsigned T_XP = 6,
  parameter int unsigned BW   = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [BW-1:0] act_banks_i,
  input  logic          busy_i,
  input  logic          idle_hint_i,
  input  logic          new_req_i,
  input  logic          ref_idle_i,
  input  logic          ref_due_i,
  input  logic          ref_drain_i,
  input  logic          refresh_i,
  input  logic          ref_done_i,
  output pwr_state_e    state_o,
  output logic          ready_o,
  output logic          pd_o
);
  localparam int unsigned XW = $clog2(T_XP + 1);

  pwr_state_e st_q, st_d;
  logic [XW-1:0] xp_q;
  logic open_b, enter_pd, wake, xp_ld;

  assign open_b   = (act_banks_i != '0);
  assign enter_pd = idle_hint_i && !busy_i && !new_req_i && ref_idle_i && !ref_due_i;
  assign wake     = new_req_i || !idle_hint_i || ref_due_i || ref_drain_i;

  always_comb begin
    st_d  = st_q;
    xp_ld = 1'b0;
    unique case (st_q)
      PS_IDLE, PS_ACT: begin
        if (refresh_i)     st_d = PS_REF;
        else if (enter_pd) st_d = open_b ? PS_PD_ACT : PS_PD_PRE;
        else               st_d = open_b ? PS_ACT : PS_IDLE;
      end
      PS_REF:            if (ref_done_i) st_d = PS_IDLE;
      PS_PD_PRE, PS_PD_ACT: begin
        if (wake) begin
          st_d  = PS_EXIT;
          xp_ld = 1'b1;
        end
      end
      PS_EXIT:           if (xp_q == '0) st_d = open_b ? PS_ACT : PS_IDLE;
      default:           st_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= PS_IDLE;
      xp_q <= '0;
    end else begin
      st_q <= st_d;
      if (xp_ld)                               xp_q <= XW'(T_XP - 1);
      else if (st_q == PS_EXIT && xp_q != '0)  xp_q <= xp_q - 1'b1;
    end
  end

  assign state_o = st_q;
  assign pd_o    = (st_q == PS_PD_PRE) || (st_q == PS_PD_ACT);
  assign ready_o = (st_q == PS_IDLE) || (st_q == PS_ACT) || (st_q == PS_REF);

  a_r8_pd_entry_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pd_o) |-> ($past(idle_hint_i) && !$past(busy_i)));
  a_r9_due_wakes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_o && ref_due_i) |=> !pd_o);

endmodule

// File: rtl/rank_pwr_ref_ctrl.sv
module rank_pwr_ref_ctrl
  import rank_ctrl_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned T_REFI    = 7800,
  parameter int unsigned T_RFC     = 280,
  parameter int unsigned T_RP      = 12,
  parameter int unsigned T_XP      = 6,
  localparam int unsigned BW       = $clog2(NUM_BANKS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [BW-1:0] act_banks_i,
  input  logic          busy_i,
  input  logic          idle_hint_i,
  input  logic          new_req_i,
  output logic          rank_avail_o,
  output logic          pre_all_o,
  output logic          refresh_o,
  output logic          pd_o,
  output logic [2:0]    pwr_state_o
);
  ref_state_e ref_st;
  pwr_state_e pwr_st;
  logic ref_idle, ref_due, ref_done, pwr_ready;

  assign ref_idle = (ref_st == REF_IDLE);

  rank_ref_timer #(.T_REFI(T_REFI)) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ref_idle_i (ref_idle),
    .reload_i   (ref_done),
    .due_o      (ref_due)
  );

  rank_ref_fsm #(.T_RP(T_RP), .T_RFC(T_RFC)) i_ref (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .due_i        (ref_due),
    .busy_i       (busy_i),
    .banks_open_i (act_banks_i != '0),
    .pwr_ready_i  (pwr_ready),
    .state_o      (ref_st),
    .pre_all_o    (pre_all_o),
    .refresh_o    (refresh_o),
    .done_o       (ref_done)
  );

  rank_pwr_fsm #(.T_XP(T_XP), .BW(BW)) i_pwr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .act_banks_i (act_banks_i),
    .busy_i      (busy_i),
    .idle_hint_i (idle_hint_i),
    .new_req_i   (new_req_i),
    .ref_idle_i  (ref_idle),
    .ref_due_i   (ref_due),
    .ref_drain_i (ref_st == REF_DRAIN),
    .refresh_i   (refresh_o),
    .ref_done_i  (ref_done),
    .state_o     (pwr_st),
    .ready_o     (pwr_ready),
    .pd_o        (pd_o)
  );

  assign rank_avail_o = ref_idle && pwr_ready && (pwr_st != PS_REF);
  assign pwr_state_o  = pwr_st;

  a_r10_no_cmd_in_pd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_o |-> !(pre_all_o || refresh_o));
  a_r10_pd_blocks_avail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_o |-> !rank_avail_o);
  a_r6_ref_hides_rank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_o |=> !rank_avail_o);

endmodule

// File: tb/test_rank_pwr_ref_ctrl.sv
`timescale 1ns/1ps
module test_rank_pwr_ref_ctrl;
  localparam int T_REFI = 100, T_RFC = 10, T_RP = 3, T_XP = 2;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [3:0] act_banks = '0;
  logic busy = 0, idle_hint = 0, new_req = 0;
  logic avail, pre_all, refresh, pd;
  logic [2:0] pstate;
  int cyc = 0, checks = 0, errors = 0;

  typedef struct { int kind; int at; string tag; } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  rank_pwr_ref_ctrl #(.NUM_BANKS(8), .T_REFI(T_REFI), .T_RFC(T_RFC),
                      .T_RP(T_RP), .T_XP(T_XP)) i_rank_pwr_ref_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .act_banks_i(act_banks), .busy_i(busy),
    .idle_hint_i(idle_hint), .new_req_i(new_req), .rank_avail_o(avail),
    .pre_all_o(pre_all), .refresh_o(refresh), .pd_o(pd), .pwr_state_o(pstate));

  always @(posedge clk) if (rst_ni) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cyc=%0d actual=%0d expected=%0d", tag, cyc, act, expv);
    end
  endtask

  task automatic push(input int kind, input int at, input string tag);
    exp_t e;
    e.kind = kind; e.at = at; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // scoreboard monitor: kind 1 = precharge-all, kind 2 = refresh
  task automatic seen(input int kind);
    exp_t e;
    if (exp_q.size() == 0) begin
      chk(0, "R3 unexpected command", kind, 0);
    end else begin
      e = exp_q.pop_front();
      chk(kind == e.kind, e.tag, kind, e.kind);
      chk(cyc == e.at, e.tag, cyc, e.at);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni) begin
      #1;
      if (pre_all) seen(1);
      if (refresh) seen(2);
    end
  end

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(avail == 1'b1, "R1 avail", avail, 1);
    chk(pd == 1'b0, "R1 pd", pd, 0);
    chk(pstate == 3'd0 && !pre_all && !refresh, "R1 state", pstate, 0);
    @(negedge clk);
    rst_ni = 1'b1;

    push(2, 100, "R5 direct refresh");
    push(2, 211, "R2 second interval");
    push(1, 330, "R3 drain held by busy");
    push(2, 333, "R4 refresh after T_RP");
    push(1, 446, "R11 pre after exit window");
    push(2, 449, "R4 refresh after wake");

    wait_cyc(99);  #1 chk(avail == 1, "R2 avail before due", avail, 1);
    wait_cyc(100); #1 chk(avail == 0, "R2 avail at drain", avail, 0);
    wait_cyc(105); #1 chk(pstate == 3'd2, "R6 refresh state", pstate, 2);
    wait_cyc(110); #1 chk(avail == 0, "R6 still refreshing", avail, 0);
    wait_cyc(111); #1 chk(avail == 1, "R6 released", avail, 1);
    wait_cyc(211); #1 chk(avail == 0, "R2 avail second drain", avail, 0);

    wait_cyc(222); act_banks = 4'd2; busy = 1;
    wait_cyc(230); #1 chk(pstate == 3'd1, "R7 active state", pstate, 1);
    wait_cyc(329); #1 chk(avail == 0, "R3 held in drain", avail, 0);
    wait_cyc(330); busy = 0;
    wait_cyc(331); act_banks = 4'd0;
    wait_cyc(336); #1 chk(pstate == 3'd2, "R6 refresh state 2", pstate, 2);
    wait_cyc(343); #1 chk(avail == 0, "R6 before release", avail, 0);
    wait_cyc(344); #1 chk(avail == 1, "R6 release", avail, 1);

    wait_cyc(350); idle_hint = 1;
    wait_cyc(351); #1 chk(pd == 1, "R8 pd entry", pd, 1);
    chk(pstate == 3'd3, "R8 closed pd", pstate, 3);
    chk(avail == 0, "R10 avail in pd", avail, 0);
    wait_cyc(360); new_req = 1; idle_hint = 0;
    wait_cyc(361); new_req = 0; #1 chk(pd == 0 && pstate == 3'd5, "R9 exit state", pstate, 5);
    wait_cyc(362); #1 chk(avail == 0, "R9 exit window", avail, 0);
    wait_cyc(363); #1 chk(avail == 1, "R9 after exit", avail, 1);

    wait_cyc(400); act_banks = 4'd3; idle_hint = 1;
    wait_cyc(401); #1 chk(pstate == 3'd4 && pd == 1, "R8 open pd", pstate, 4);
    wait_cyc(443); #1 chk(pd == 1, "R9 pd until due", pd, 1);
    wait_cyc(444); #1 chk(pd == 0 && pstate == 3'd5, "R9 due wakes", pstate, 5);
    wait_cyc(445); #1 chk(avail == 0, "R11 drain waits", avail, 0);
    wait_cyc(447); act_banks = 4'd0; idle_hint = 0;
    wait_cyc(455); #1 chk(pstate == 3'd2, "R6 refresh after wake", pstate, 2);
    wait_cyc(460); #1 chk(avail == 1, "R6 release after wake", avail, 1);

    wait_cyc(470); idle_hint = 1; busy = 1;
    wait_cyc(472); #1 chk(pd == 0, "R8 busy blocks pd", pd, 0);
    wait_cyc(475); busy = 0;
    wait_cyc(476); #1 chk(pd == 1 && pstate == 3'd3, "R8 pd after quiet", pstate, 3);
    wait_cyc(480); new_req = 1; idle_hint = 0;
    wait_cyc(481); new_req = 0;
    wait_cyc(482); #1 chk(avail == 0, "R9 second exit window", avail, 0);
    wait_cyc(483); #1 chk(avail == 1, "R9 second release", avail, 1);
    wait_cyc(490); #1 chk(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule